// File: doc/BRIEF.md
# Processor Trace Status Encoder

This block turns instruction retirement events from a simple CPU into two 4-bit trace streams: a status stream that marks instruction boundaries and announces data, and a data stream that carries operand values or branch target addresses one nibble per clock. Each event carries a start strobe, an optional memory operand with its size and direction, and an optional change-of-flow target address with its length.

For every accepted event, the status output first shows the instruction-start code. If the operand is to be shown, a size code follows and the operand bytes are then shifted out. After that, if a target is to be shown, a target length code follows and the target bytes are shifted out. Three configuration bits decide what is shown: operands that are read, operands that are written, and branch targets. The block holds its ready output low while a sequence is under way, so the event source stalls until the trace of the previous instruction has finished.

Top module: `trace_status_enc`

## Requirements
- R1: When an event is accepted (`evt_valid` and `evt_ready` both high at a rising edge), `pst_o` is 0x1 in the following cycle.
- R2: A shown operand is announced in the cycle after the 0x1 code with a size code: `opnd_size` 0 (1 byte) gives 0x8, 1 (2 bytes) gives 0x9, and 2 or 3 (4 bytes) gives 0xB.
- R3: A shown target is announced with a length code: `cof_len` 0 (2 bytes) gives 0x9, 1 (3 bytes) gives 0xA, and 2 or 3 (4 bytes) gives 0xB. This code comes after the operand data if an operand is shown, and otherwise in the cycle after the 0x1 code.
- R4: A memory operand is shown only if its direction is enabled: a read (`opnd_write`=0) needs `cfg_show_rd`=1, and a write (`opnd_write`=1) needs `cfg_show_wr`=1.
- R5: An operand with `opnd_mem`=0 (register direct) never produces a size code or data.
- R6: A target is shown only when `cof_valid`=1 and `cfg_show_tgt`=1. Otherwise no target code and no target data appear.
- R7: Data starts in the cycle after its size code. It is sent as the low bytes of the value, least significant nibble first, one nibble per cycle, two nibbles per byte.
- R8: `pst_o` is 0x0 in every cycle that carries no code, and `ddata_o` is 0x0 in every cycle that does not carry a data nibble.
- R9: `evt_ready` is low from the cycle after an acceptance up to and including the cycle that carries the last code or nibble of that instruction, and high when the block is idle.
- R10: A synchronous reset (`rst`=1) stops any sequence in progress. In the cycle after reset, `pst_o` and `ddata_o` are 0x0 and `evt_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_valid | input | 1 | Instruction-start strobe from the CPU |
| evt_ready | output | 1 | Block can accept an event |
| opnd_mem | input | 1 | The operand references memory |
| opnd_write | input | 1 | Operand direction: 1 write, 0 read |
| opnd_size | input | 2 | Operand size: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| opnd_data | input | 32 | Operand value, low bytes used |
| cof_valid | input | 1 | The instruction is a change of flow |
| cof_len | input | 2 | Target length: 0 = 2 bytes, 1 = 3 bytes, 2 or 3 = 4 bytes |
| cof_target | input | 32 | Target address, low bytes used |
| cfg_show_rd | input | 1 | Show read operands |
| cfg_show_wr | input | 1 | Show write operands |
| cfg_show_tgt | input | 1 | Show branch targets |
| pst_o | output | 4 | Status code stream |
| ddata_o | output | 4 | Data nibble stream |

## Verification
The bench sweeps every combination of the three configuration bits, operand memory flag, direction, size, change-of-flow flag and target length, and it compares each cycle of the trace with a sequence it builds from the requirements. The weak spots are the overlapping code values. A design that confused the operand and target tables would send 0x8 or the wrong length for a target, and a design that mixed up the filter bits would leak writes when only reads are enabled. Nibble order and count are checked at the 1-, 2-, 3- and 4-byte sizes, so a design that sent the high nibble first or stopped one nibble early would fail. A reset during a 4-byte shift checks that no data follows the reset.

// File: rtl/trace_status_enc.sv
module trace_status_enc #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evt_valid,
  output logic          evt_ready,
  input  logic          opnd_mem,
  input  logic          opnd_write,
  input  logic [1:0]    opnd_size,
  input  logic [DW-1:0] opnd_data,
  input  logic          cof_valid,
  input  logic [1:0]    cof_len,
  input  logic [DW-1:0] cof_target,
  input  logic          cfg_show_rd,
  input  logic          cfg_show_wr,
  input  logic          cfg_show_tgt,
  output logic [3:0]    pst_o,
  output logic [3:0]    ddata_o
);
  localparam int CW = $clog2(DW/4 + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_OPMK, S_OPDAT, S_TGMK, S_TGDAT} st_t;

  st_t            st;
  logic [3:0]     mk, op_code, tg_code;
  logic           op_show, tg_show;
  logic [DW-1:0]  op_dat, tg_dat, shreg;
  logic [CW-1:0]  cnt;
  logic           accept;
  logic [3:0]     op_code_in, tg_code_in;
  logic [CW-1:0]  nib;

  assign evt_ready  = (st == S_IDLE);
  assign accept     = evt_valid && evt_ready;
  assign op_code_in = (opnd_size == 2'd0) ? 4'h8 : (opnd_size == 2'd1) ? 4'h9 : 4'hB;
  assign tg_code_in = (cof_len == 2'd0) ? 4'h9 : (cof_len == 2'd1) ? 4'hA : 4'hB;
  assign nib        = CW'((mk[1:0] + 3'd1) << 1);

  assign pst_o   = (st == S_START) ? 4'h1 :
                   (st == S_OPMK || st == S_TGMK) ? mk : 4'h0;
  assign ddata_o = (st == S_OPDAT || st == S_TGDAT) ? shreg[3:0] : 4'h0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      mk      <= 4'h0;
      op_show <= 1'b0;
      tg_show <= 1'b0;
      op_code <= 4'h0;
      tg_code <= 4'h0;
      op_dat  <= '0;
      tg_dat  <= '0;
      shreg   <= '0;
      cnt     <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          op_show <= opnd_mem && (opnd_write ? cfg_show_wr : cfg_show_rd);
          tg_show <= cof_valid && cfg_show_tgt;
          op_code <= op_code_in;
          tg_code <= tg_code_in;
          op_dat  <= opnd_data;
          tg_dat  <= cof_target;
          st      <= S_START;
        end
        S_START: begin
          if (op_show) begin
            mk <= op_code;
            st <= S_OPMK;
          end else if (tg_show) begin
            mk <= tg_code;
            st <= S_TGMK;
          end else begin
            st <= S_IDLE;
          end
        end
        S_OPMK, S_TGMK: begin
          shreg <= (st == S_OPMK) ? op_dat : tg_dat;
          cnt   <= nib;
          st    <= (st == S_OPMK) ? S_OPDAT : S_TGDAT;
        end
        S_OPDAT, S_TGDAT: begin
          shreg <= shreg >> 4;
          cnt   <= cnt - CW'(1);
          if (cnt == CW'(1)) begin
            if (st == S_OPDAT && tg_show) begin
              mk <= tg_code;
              st <= S_TGMK;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_START_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    accept |=> pst_o == 4'h1); // R1
  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
    pst_o inside {4'h0, 4'h1, 4'h8, 4'h9, 4'hA, 4'hB}); // R2
  AST_CODE_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    pst_o != 4'h0 |-> ddata_o == 4'h0); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    evt_ready |-> (pst_o == 4'h0 && ddata_o == 4'h0)); // R8
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    pst_o == 4'h1 |-> !evt_ready); // R9
  AST_NO_SECOND_START: assert property (@(posedge clk) disable iff (rst)
    pst_o == 4'h1 |=> pst_o != 4'h1); // R9
endmodule

// File: tb/tb_trace_status_enc.sv
module tb_trace_status_enc;
  logic        clk = 0, rst = 1;
  logic        evt_valid = 0, evt_ready;
  logic        opnd_mem = 0, opnd_write = 0;
  logic [1:0]  opnd_size = 0, cof_len = 0;
  logic [31:0] opnd_data = 0, cof_target = 0;
  logic        cof_valid = 0, cfg_show_rd = 0, cfg_show_wr = 0, cfg_show_tgt = 0;
  logic [3:0]  pst_o, ddata_o;
  int          nchk = 0, nfail = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  trace_status_enc dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_one(input bit m, input bit w, input logic [1:0] sz,
                         input bit cv, input logic [1:0] cl, input logic [31:0] od,
                         input logic [31:0] ct);
    logic [3:0] ep[20];
    logic [3:0] ed[20];
    int p, nb;
    bit pok, dok, rok;
    int bk, ba, be;
    for (int i = 0; i < 20; i++) begin ep[i] = 0; ed[i] = 0; end
    ep[0] = 4'h1; p = 1;
    if (m && (w ? cfg_show_wr : cfg_show_rd)) begin // R2 R4 R5
      ep[p] = (sz == 0) ? 4'h8 : (sz == 1) ? 4'h9 : 4'hB;
      nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
      p++;
      for (int i = 0; i < 2*nb; i++) begin ed[p] = 4'((od >> (4*i)) & 32'hF); p++; end // R7
    end
    if (cv && cfg_show_tgt) begin // R3 R6
      ep[p] = (cl == 0) ? 4'h9 : (cl == 1) ? 4'hA : 4'hB;
      nb = (cl == 0) ? 2 : (cl == 1) ? 3 : 4;
      p++;
      for (int i = 0; i < 2*nb; i++) begin ed[p] = 4'((ct >> (4*i)) & 32'hF); p++; end
    end
    opnd_mem = m; opnd_write = w; opnd_size = sz; opnd_data = od;
    cof_valid = cv; cof_len = cl; cof_target = ct; evt_valid = 1;
    @(negedge clk);
    evt_valid = 0;
    pok = 1; dok = 1; rok = 1; bk = 0; ba = 0; be = 0;
    for (int k = 0; k < 20; k++) begin
      if (pok && pst_o !== ep[k]) begin pok = 0; bk = k; ba = pst_o; be = ep[k]; end
      if (dok && ddata_o !== ed[k]) begin dok = 0; if (pok) begin bk = k; ba = ddata_o; be = ed[k]; end end
      if (rok && evt_ready !== (k >= p)) rok = 0;
      if (k < 19) @(negedge clk);
    end
    chk(pok, (bk == 0) ? "R1 pst" : "R2/R3/R4/R5/R6 pst", ba, be);
    chk(dok, "R7/R8 ddata", ba, be);
    chk(rok, "R9 ready", 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(pst_o == 0 && ddata_o == 0 && evt_ready == 1, "R10 reset state", {pst_o, ddata_o}, 0);
    rst = 0;
    @(negedge clk);
    for (int c = 0; c < 8; c++) begin
      cfg_show_rd = c[0]; cfg_show_wr = c[1]; cfg_show_tgt = c[2];
      for (int m = 0; m < 2; m++)
        for (int w = 0; w < 2; w++)
          for (int sz = 0; sz < 4; sz++)
            for (int cv = 0; cv < 2; cv++)
              for (int cl = 0; cl < 4; cl++)
                run_one(m[0], w[0], sz[1:0], cv[0], cl[1:0],
                        32'h8D2F_61B3 ^ (32'h1357_9BDF * (c*64 + sz*16 + cl)),
                        32'hC4A7_0E59 + 32'h0F1E_2D3C * (m + 2*w + 4*cv + sz));
    end
    cfg_show_rd = 1; cfg_show_wr = 1; cfg_show_tgt = 1;
    opnd_mem = 1; opnd_write = 0; opnd_size = 2; opnd_data = 32'h7654_3210;
    cof_valid = 1; cof_len = 2; evt_valid = 1;
    @(negedge clk);
    evt_valid = 0;
    repeat (4) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    for (int k = 0; k < 12; k++) begin
      chk(pst_o == 0 && ddata_o == 0 && evt_ready == 1, "R10 reset mid-shift", {pst_o, ddata_o}, 0);
      @(negedge clk);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule